// File: doc/BRIEF.md
# Bridge Protection Sequencer

This block decides, cycle by cycle, whether each power bridge of a motor driver may conduct and whether the shared fault line is pulled low. It takes one overcurrent flag per bridge, one die-temperature flag and one supply-low flag from analog detectors outside the block. Each flag passes through a synchronizer before any logic sees it.

An overcurrent flag must stay high for a qualification window before it counts. A qualified overcurrent turns off only its own bridge and pulls the fault line low for a fixed hold-off time. When that time ends, the bridge is switched back on and the fault line is released. If the flag is still high, the same sequence runs again. A high temperature turns off every bridge and reports a fault until the flag drops. A low supply turns off every bridge and clears all overcurrent state, but it does not report a fault. Normal operation resumes as soon as the supply recovers.

The fault output is the active-low level that controls an open-drain pull-down. A low level means the pad is pulled to ground.

Top module: `bridge_guard`

## Requirements
- R1: While `rst_n` is low, and for RST_STAGES clock edges after it rises, every bit of `bridge_off` is 1 and `fault_n` is 1.
- R2: If `oc_flag[i]` stays high, `bridge_off[i]` goes to 1 and `fault_n` goes to 0 exactly SYNC_STAGES+DEGLITCH_CYC clock edges after the flag rises.
- R3: An overcurrent pulse that lasts fewer than DEGLITCH_CYC synchronized cycles causes no action. The qualification count restarts from zero at every pulse, so repeated short pulses never add up to a trip.
- R4: After an overcurrent trip, `bridge_off[i]` stays 1 for exactly RETRY_CYC cycles. Then it returns to 0, and `fault_n` returns to 1 unless some other bridge or the temperature flag still holds it low.
- R5: If the overcurrent flag is still high when the bridge is re-enabled, the bridge trips again DEGLITCH_CYC cycles later. If the flag has cleared, the bridge stays enabled.
- R6: An overcurrent trip on one bridge leaves the `bridge_off` bits of all other bridges unchanged.
- R7: SYNC_STAGES edges after `therm_flag` rises, all `bridge_off` bits are 1 and `fault_n` is 0. SYNC_STAGES edges after `therm_flag` falls, both outputs return to their overcurrent-driven values.
- R8: SYNC_STAGES edges after `uv_flag` rises, all `bridge_off` bits are 1 and `fault_n` is 1. The flag also cancels any overcurrent hold-off or qualification count that is in progress.
- R9: A low supply overrides a high temperature, and a high temperature overrides overcurrent. While the temperature flag is high, all overcurrent counts are held at zero, so a fresh qualification window starts only after the flag drops.
- R10: `fault_n` is 0 only when at least one bridge is disabled and no low-supply condition is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronized inside the block |
| oc_flag | input | N_BRIDGES | Raw overcurrent flag, one bit per bridge |
| therm_flag | input | 1 | Raw die over-temperature flag |
| uv_flag | input | 1 | Raw supply-low flag |
| bridge_off | output | N_BRIDGES | 1 turns off all switches of that bridge |
| fault_n | output | 1 | Active-low fault level that drives the open-drain pull-down |

## Verification
Every result has a fixed latency, counted in clock edges from the falling clock edge at which an input changes:
- A temperature or supply change reaches the outputs after SYNC_STAGES edges.
- An overcurrent trip appears after SYNC_STAGES+DEGLITCH_CYC edges.
- A hold-off ends exactly RETRY_CYC edges after the trip.
- A re-trip follows DEGLITCH_CYC edges after that.

The bench drives inputs and samples outputs only on falling clock edges. For each result it samples once at the last edge before the result is due, expecting the old value, and once at the edge where it is due, expecting the new value. Each check therefore pins the exact cycle, not just eventual behaviour.

// File: rtl/guard_pkg.sv
package guard_pkg;

  // Overcurrent channel phases: watching the flag, or holding the bridge off.
  typedef enum logic {
    OC_WATCH = 1'b0,
    OC_HOLD  = 1'b1
  } oc_state_e;

  function automatic int unsigned max_of(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/guard_rst_sync.sv
// Reset conditioner: asserts asynchronously, releases on the clock.
module guard_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ok
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_ok = chain_q[STAGES-1];

endmodule

// File: rtl/guard_flag_sync.sv
// Multi-stage synchronizer for the raw detector flags.
module guard_flag_sync #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] raw,
  output logic [WIDTH-1:0] synced
);

  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [WIDTH-1:0] stage_d;
    if (s == 0) begin : g_first
      assign stage_d = raw;
    end else begin : g_next
      assign stage_d = stage_q[s-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage_q[s] <= '0;
      end else begin
        stage_q[s] <= stage_d;
      end
    end
  end

  assign synced = stage_q[STAGES-1];

endmodule

// File: rtl/guard_oc_channel.sv
// One overcurrent channel: qualification count followed by a timed hold-off.
module guard_oc_channel
  import guard_pkg::*;
#(
  parameter int unsigned DEGLITCH_CYC = 412,
  parameter int unsigned RETRY_CYC    = 168750
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic oc,
  output logic hold
);

  localparam int unsigned            CNT_W   = $clog2(max_of(DEGLITCH_CYC, RETRY_CYC) + 1);
  localparam logic [CNT_W-1:0]       DG_LAST = CNT_W'(DEGLITCH_CYC - 1);
  localparam logic [CNT_W-1:0]       RT_LAST = CNT_W'(RETRY_CYC - 1);
  localparam logic [CNT_W-1:0]       ONE     = CNT_W'(1);

  oc_state_e        state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             upd_en;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    if (clr) begin
      state_d = OC_WATCH;
      cnt_d   = '0;
    end else begin
      case (state_q)
        OC_WATCH: begin
          if (oc) begin
            if (cnt_q == DG_LAST) begin
              state_d = OC_HOLD;
              cnt_d   = '0;
            end else begin
              cnt_d = cnt_q + ONE;
            end
          end else begin
            cnt_d = '0;
          end
        end
        OC_HOLD: begin
          if (cnt_q == RT_LAST) begin
            state_d = OC_WATCH;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_q + ONE;
          end
        end
      endcase
    end
  end

  assign upd_en = (state_d != state_q) || (cnt_d != cnt_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= OC_WATCH;
      cnt_q   <= '0;
    end else if (upd_en) begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign hold = (state_q == OC_HOLD);

endmodule

// File: rtl/guard_fault_merge.sv
// Applies the source priority: supply-low, then temperature, then overcurrent.
module guard_fault_merge #(
  parameter int unsigned N_BRIDGES = 2
) (
  input  logic                 rst_ok,
  input  logic                 uv,
  input  logic                 therm,
  input  logic [N_BRIDGES-1:0] hold,
  output logic [N_BRIDGES-1:0] bridge_off,
  output logic                 fault_n
);

  logic all_off;
  logic report;

  always_comb begin
    all_off    = !rst_ok || uv || therm;
    bridge_off = {N_BRIDGES{all_off}} | hold;
    report     = rst_ok && !uv && (therm || (|hold));
    fault_n    = !report;
  end

endmodule

// File: rtl/bridge_guard.sv
module bridge_guard #(
  parameter int unsigned N_BRIDGES    = 2,
  parameter int unsigned SYNC_STAGES  = 2,
  parameter int unsigned RST_STAGES   = 2,
  parameter int unsigned DEGLITCH_CYC = 412,
  parameter int unsigned RETRY_CYC    = 168750
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N_BRIDGES-1:0] oc_flag,
  input  logic                 therm_flag,
  input  logic                 uv_flag,
  output logic [N_BRIDGES-1:0] bridge_off,
  output logic                 fault_n
);

  localparam int unsigned FLAG_W = N_BRIDGES + 2;

  logic                 rst_ok;
  logic [FLAG_W-1:0]    flags_s;
  logic [N_BRIDGES-1:0] oc_s;
  logic                 therm_s;
  logic                 uv_s;
  logic                 chan_clr;
  logic [N_BRIDGES-1:0] oc_hold;

  guard_rst_sync #(
    .STAGES (RST_STAGES)
  ) u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_ok (rst_ok)
  );

  guard_flag_sync #(
    .WIDTH  (FLAG_W),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk    (clk),
    .rst_n  (rst_ok),
    .raw    ({uv_flag, therm_flag, oc_flag}),
    .synced (flags_s)
  );

  assign oc_s     = flags_s[N_BRIDGES-1:0];
  assign therm_s  = flags_s[N_BRIDGES];
  assign uv_s     = flags_s[N_BRIDGES+1];
  assign chan_clr = uv_s || therm_s;

  for (genvar b = 0; b < N_BRIDGES; b++) begin : g_chan
    guard_oc_channel #(
      .DEGLITCH_CYC (DEGLITCH_CYC),
      .RETRY_CYC    (RETRY_CYC)
    ) u_chan (
      .clk   (clk),
      .rst_n (rst_ok),
      .clr   (chan_clr),
      .oc    (oc_s[b]),
      .hold  (oc_hold[b])
    );
  end

  guard_fault_merge #(
    .N_BRIDGES (N_BRIDGES)
  ) u_merge (
    .rst_ok     (rst_ok),
    .uv         (uv_s),
    .therm      (therm_s),
    .hold       (oc_hold),
    .bridge_off (bridge_off),
    .fault_n    (fault_n)
  );

endmodule

// File: rtl/guard_checker.sv
module guard_checker #(
  parameter int unsigned N_BRIDGES = 2,
  parameter int unsigned RETRY_CYC = 168750
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 rst_ok,
  input logic                 uv_s,
  input logic                 therm_s,
  input logic [N_BRIDGES-1:0] hold,
  input logic [N_BRIDGES-1:0] bridge_off,
  input logic                 fault_n
);

  localparam int unsigned RUN_W = $clog2(RETRY_CYC + 1) + 1;

  p_reset_safe_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_ok |-> ((&bridge_off) && fault_n));

  p_therm_all_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_ok && therm_s && !uv_s) |-> ((&bridge_off) && !fault_n));

  p_uv_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_ok && uv_s) |-> ((&bridge_off) && fault_n));

  p_uv_clears_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_ok && uv_s) |=> (hold == '0));

  p_fault_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !fault_n |-> ((|bridge_off) && !uv_s));

  for (genvar b = 0; b < N_BRIDGES; b++) begin : g_bridge
    logic [RUN_W-1:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        run_q <= '0;
      end else if (hold[b]) begin
        run_q <= run_q + RUN_W'(1);
      end else begin
        run_q <= '0;
      end
    end

    p_hold_disables_r2: assert property (@(posedge clk) disable iff (!rst_n)
      hold[b] |-> bridge_off[b]);

    p_retry_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
      hold[b] |-> (run_q < RUN_W'(RETRY_CYC)));
  end

endmodule

bind bridge_guard guard_checker #(
  .N_BRIDGES (N_BRIDGES),
  .RETRY_CYC (RETRY_CYC)
) u_guard_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .rst_ok     (rst_ok),
  .uv_s       (uv_s),
  .therm_s    (therm_s),
  .hold       (oc_hold),
  .bridge_off (bridge_off),
  .fault_n    (fault_n)
);

// File: tb/test_bridge_guard.sv
`timescale 1ns/1ps
module test_bridge_guard;

  localparam int unsigned NB   = 2;
  localparam int unsigned SYNC = 2;
  localparam int unsigned RSTS = 2;
  localparam int unsigned DG   = 6;
  localparam int unsigned RT   = 20;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NB-1:0] oc_flag;
  logic          therm_flag;
  logic          uv_flag;
  logic [NB-1:0] bridge_off;
  logic          fault_n;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #4 clk = ~clk;

  bridge_guard #(
    .N_BRIDGES    (NB),
    .SYNC_STAGES  (SYNC),
    .RST_STAGES   (RSTS),
    .DEGLITCH_CYC (DG),
    .RETRY_CYC    (RT)
  ) i_bridge_guard (
    .clk        (clk),
    .rst_n      (rst_n),
    .oc_flag    (oc_flag),
    .therm_flag (therm_flag),
    .uv_flag    (uv_flag),
    .bridge_off (bridge_off),
    .fault_n    (fault_n)
  );

  task automatic tick(input int unsigned n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [NB-1:0] exp_off, input logic exp_f);
    n_checks++;
    if (bridge_off !== exp_off || fault_n !== exp_f) begin
      n_fail++;
      $display("FAIL %s: bridge_off=%b fault_n=%b, expected bridge_off=%b fault_n=%b",
               req, bridge_off, fault_n, exp_off, exp_f);
    end
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  // R1: reset holds bridges off and fault released until the synchronized release
  task automatic t_reset();
    rst_n = 1'b0; oc_flag = '0; therm_flag = 1'b0; uv_flag = 1'b0;
    tick(3);
    check("R1 in reset", 2'b11, 1'b1);
    rst_n = 1'b1;
    tick(RSTS - 1);
    check("R1 release pending", 2'b11, 1'b1);
    tick(1);
    check("R1 after release", 2'b00, 1'b1);
  endtask

  // R3: short pulses never trip, and they do not add up
  task automatic t_glitch();
    bit bad = 1'b0;
    for (int p = 0; p < 3; p++) begin
      oc_flag[0] = 1'b1;
      tick(DG - 1);
      oc_flag[0] = 1'b0;
      for (int c = 0; c < SYNC + 2; c++) begin
        tick(1);
        if (bridge_off !== 2'b00 || fault_n !== 1'b1) bad = 1'b1;
      end
    end
    n_checks++;
    if (bad) begin
      n_fail++;
      $display("FAIL R3: short pulse acted, bridge_off=%b fault_n=%b, expected 00/1",
               bridge_off, fault_n);
    end
  endtask

  // R2 R4 R5 R6: trip timing, hold-off length, re-trip and recovery
  task automatic t_trip_retry();
    oc_flag[0] = 1'b1;
    tick(SYNC + DG - 1);
    check("R2 before qualification", 2'b00, 1'b1);
    tick(1);
    check("R2 trip, R6 other bridge running", 2'b01, 1'b0);
    tick(RT - 1);
    check("R4 last hold cycle", 2'b01, 1'b0);
    tick(1);
    check("R4 re-enabled", 2'b00, 1'b1);
    tick(DG - 1);
    check("R5 before re-trip", 2'b00, 1'b1);
    tick(1);
    check("R5 re-trip", 2'b01, 1'b0);
    oc_flag[0] = 1'b0;
    tick(RT + SYNC + DG + 2);
    check("R5 cleared stays enabled", 2'b00, 1'b1);
  endtask

  // R6: both bridges trip independently
  task automatic t_two_bridges();
    oc_flag[1] = 1'b1;
    tick(3);
    oc_flag[0] = 1'b1;
    tick(SYNC + DG - 3);
    check("R6 bridge1 tripped alone", 2'b10, 1'b0);
    tick(3);
    check("R6 both tripped", 2'b11, 1'b0);
    oc_flag = '0;
    tick(RT - 3);
    check("R6 bridge1 released first", 2'b01, 1'b0);
    tick(3);
    check("R6 both released", 2'b00, 1'b1);
  endtask

  // R7: thermal shuts all bridges and reports
  task automatic t_thermal();
    therm_flag = 1'b1;
    tick(SYNC - 1);
    check("R7 before thermal", 2'b00, 1'b1);
    tick(1);
    check("R7 thermal active", 2'b11, 1'b0);
    tick(10);
    therm_flag = 1'b0;
    tick(SYNC - 1);
    check("R7 thermal still held", 2'b11, 1'b0);
    tick(1);
    check("R7 thermal cleared", 2'b00, 1'b1);
  endtask

  // R8: supply-low disables silently and cancels overcurrent state
  task automatic t_uv();
    uv_flag = 1'b1;
    tick(SYNC);
    check("R8 undervoltage quiet", 2'b11, 1'b1);
    uv_flag = 1'b0;
    tick(SYNC);
    check("R8 undervoltage cleared", 2'b00, 1'b1);
    oc_flag[1] = 1'b1;
    tick(SYNC + DG);
    check("R8 setup trip", 2'b10, 1'b0);
    oc_flag[1] = 1'b0;
    uv_flag    = 1'b1;
    tick(SYNC);
    check("R8 during hold", 2'b11, 1'b1);
    uv_flag = 1'b0;
    tick(SYNC);
    check("R8 hold cancelled", 2'b00, 1'b1);
  endtask

  // R9: priority combinations
  task automatic t_priority();
    therm_flag = 1'b1; uv_flag = 1'b1;
    tick(SYNC);
    check("R9 uv over thermal", 2'b11, 1'b1);
    uv_flag = 1'b0;
    tick(SYNC);
    check("R9 thermal after uv", 2'b11, 1'b0);
    oc_flag[0] = 1'b1;
    tick(SYNC + DG + 4);
    check("R9 thermal over oc", 2'b11, 1'b0);
    therm_flag = 1'b0;
    tick(SYNC);
    check("R9 oc count restarted", 2'b00, 1'b1);
    tick(DG - 1);
    check("R9 fresh window pending", 2'b00, 1'b1);
    tick(1);
    check("R9 oc trips after thermal", 2'b01, 1'b0);
    uv_flag = 1'b1; therm_flag = 1'b1;
    tick(SYNC);
    check("R9 uv over all", 2'b11, 1'b1);
    oc_flag = '0; uv_flag = 1'b0; therm_flag = 1'b0;
    tick(SYNC + 1);
    check("R9 all clear", 2'b00, 1'b1);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run did not end, actual hung, expected completion");
      finish_up();
    end
  end

  initial begin : main
    rst_n = 1'b0; oc_flag = '0; therm_flag = 1'b0; uv_flag = 1'b0;
    @(negedge clk);
    t_reset();
    t_glitch();
    t_trip_retry();
    t_two_bridges();
    t_thermal();
    t_uv();
    t_priority();
    done = 1'b1;
    finish_up();
  end

endmodule